// File: doc/BRIEF.md
# Conversion Result Holding and DMA Request Controller

This block receives each finished conversion from a converter's sequencer as a one-cycle end-of-conversion strobe with its sample. It holds the latest sample in a result register and raises a ready flag until the sample is consumed. A sample is consumed either by a processor read or by an acknowledge from a DMA engine. If a new sample arrives while the held one is still unread, the block raises a sticky overrun flag. Depending on the selected policy, it then either keeps the unread sample or replaces it with the new one. The overrun interrupt output follows the flag when its enable is set.

DMA requests work in one of three ways. They can be off. They can be limited, where requests stop after a programmed number of acknowledged transfers. They can be unlimited, where every sample produces a request. In unlimited mode, a DMA engine that stops acknowledging causes an overrun on the next sample. As an alternative to DMA, samples can be forwarded to a downstream filter over a one-cycle valid/data interface. Forwarding works only while DMA is off. All configuration inputs are taken into the block only while no conversion is in progress.

Top module: `adc_result_port`

## Requirements
- R1: After reset, `data_out` is 0, and `data_rdy`, `dma_req`, `ovr_flag`, `ovr_irq` and `fwd_valid` are all 0.
- R2: An `eoc` pulse with no pending sample loads `eoc_data` into `data_out` and sets `data_rdy` from the next cycle on. A `cpu_rd` pulse clears `data_rdy` in the following cycle.
- R3: An `eoc` pulse while `data_rdy` is 1, with no `cpu_rd` and no accepted DMA acknowledge in the same cycle, sets `ovr_flag`. If a read coincides with the `eoc`, there is no overrun, and the new sample is loaded with `data_rdy` left at 1.
- R4: When the overwrite setting `cfg_ovr_overwrite` is 0 (the reset default), an overrun leaves `data_out` unchanged.
- R5: When `cfg_ovr_overwrite` is 1, an overrun loads the new sample into `data_out`, and `ovr_flag` is still set.
- R6: `ovr_flag` remains 1 until a cycle with `ovr_clr` = 1 and no new overrun. `ovr_irq` equals `ovr_flag` AND `ovr_irq_en`.
- R7: `cfg_xfer_mode` encoding: 2'b00 means no DMA, 2'b01 limited, 2'b10 unlimited, and 2'b11 behaves as no DMA. With no DMA, `dma_req` stays 0.
- R8: In limited mode, `dma_req` equals `data_rdy` until `cfg_xfer_len` acknowledged transfers have been counted, and stays 0 after that. A `dma_ack` while `dma_req` is 1 clears `data_rdy` in the following cycle.
- R9: In unlimited mode, every pending sample raises `dma_req`. If a sample is left unacknowledged, the next `eoc` sets `ovr_flag`.
- R10: A `cfg_dma_load` pulse resets the limited-mode transfer count to zero, so requests resume for a pending sample.
- R11: With `cfg_fwd_en` = 1 and DMA off, `fwd_valid` pulses for one cycle, one cycle after `eoc`, and `fwd_data` carries that sample. With a DMA mode selected, `fwd_valid` stays 0.
- R12: `cfg_ovr_overwrite`, `cfg_xfer_mode`, `cfg_fwd_en`, `cfg_xfer_len` and `cfg_dma_load` take effect only in cycles where `conv_busy` is 0. While `conv_busy` is 1, the previous settings remain in force.
- R13: A `dma_ack` while `dma_req` is 0 has no effect on `data_rdy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_busy | input | 1 | Conversion in progress; blocks configuration updates |
| cfg_ovr_overwrite | input | 1 | 0 keeps the unread sample on overrun, 1 replaces it |
| cfg_xfer_mode | input | 2 | DMA mode: 00 off, 01 limited, 10 unlimited, 11 off |
| cfg_xfer_len | input | CNT_W | Transfer count for limited mode |
| cfg_dma_load | input | 1 | Pulse that resets the transfer count |
| cfg_fwd_en | input | 1 | Enables forwarding to the filter |
| ovr_irq_en | input | 1 | Overrun interrupt enable |
| eoc | input | 1 | End-of-conversion strobe |
| eoc_data | input | DATA_W | Sample delivered with `eoc` |
| cpu_rd | input | 1 | Processor read of the result register |
| dma_ack | input | 1 | DMA acknowledge |
| ovr_clr | input | 1 | Write-one-to-clear for the overrun flag |
| data_out | output | DATA_W | Result register |
| data_rdy | output | 1 | Unread sample pending |
| dma_req | output | 1 | DMA request |
| ovr_flag | output | 1 | Sticky overrun flag |
| ovr_irq | output | 1 | Overrun interrupt |
| fwd_valid | output | 1 | Forwarded sample valid |
| fwd_data | output | DATA_W | Forwarded sample |

## Verification
Some behaviours are checked by assertions on every cycle:
- the ready flag drops only after a read or an accepted acknowledge;
- the overrun flag rises only on a sample that arrives while one is pending;
- the overrun flag falls only after a clear;
- in keep mode, the result register is frozen across an overrun;
- in unlimited mode, an unacknowledged pending sample followed by a new one always raises the overrun.

The bench scenarios are needed for the rest. They sweep the transfer-count limit and every combination of overrun policy and interrupt enable. They also cover the count reload, the busy-gated configuration, and the forwarding pulse and its suppression under DMA, all of which depend on sequences of settings.

// File: rtl/adc_result_port.sv
module adc_result_port #(
  parameter int DATA_W = 12,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_busy,
  input  logic              cfg_ovr_overwrite,
  input  logic [1:0]        cfg_xfer_mode,
  input  logic [CNT_W-1:0]  cfg_xfer_len,
  input  logic              cfg_dma_load,
  input  logic              cfg_fwd_en,
  input  logic              ovr_irq_en,
  input  logic              eoc,
  input  logic [DATA_W-1:0] eoc_data,
  input  logic              cpu_rd,
  input  logic              dma_ack,
  input  logic              ovr_clr,
  output logic [DATA_W-1:0] data_out,
  output logic              data_rdy,
  output logic              dma_req,
  output logic              ovr_flag,
  output logic              ovr_irq,
  output logic              fwd_valid,
  output logic [DATA_W-1:0] fwd_data
);
  localparam logic [1:0] MODE_LIM = 2'b01;
  localparam logic [1:0] MODE_UNL = 2'b10;

  logic              act_ow, act_fwd;
  logic [1:0]        act_mode;
  logic [CNT_W-1:0]  act_len, xfer_cnt;
  logic              cfg_open, is_lim, is_unl, dma_on;
  logic              take, consume, overrun, load_data;

  assign cfg_open  = !conv_busy;
  assign is_lim    = act_mode == MODE_LIM;
  assign is_unl    = act_mode == MODE_UNL;
  assign dma_on    = is_lim || is_unl;
  assign dma_req   = data_rdy && (is_unl || (is_lim && xfer_cnt < act_len));
  assign take      = dma_ack && dma_req;
  assign consume   = cpu_rd || take;
  assign overrun   = eoc && data_rdy && !consume;
  assign load_data = eoc && (!overrun || act_ow);
  assign ovr_irq   = ovr_flag && ovr_irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_ow   <= 1'b0;
      act_fwd  <= 1'b0;
      act_mode <= 2'b00;
      act_len  <= '0;
    end else if (cfg_open) begin
      act_ow   <= cfg_ovr_overwrite;
      act_fwd  <= cfg_fwd_en;
      act_mode <= cfg_xfer_mode;
      act_len  <= cfg_xfer_len;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     xfer_cnt <= '0;
    else if (cfg_open && cfg_dma_load) xfer_cnt <= '0;
    else if (take && is_lim)        xfer_cnt <= xfer_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_out <= '0;
      data_rdy <= 1'b0;
      ovr_flag <= 1'b0;
    end else begin
      if (load_data) data_out <= eoc_data;
      if (eoc)          data_rdy <= 1'b1;
      else if (consume) data_rdy <= 1'b0;
      if (overrun)      ovr_flag <= 1'b1;
      else if (ovr_clr) ovr_flag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fwd_valid <= 1'b0;
      fwd_data  <= '0;
    end else begin
      fwd_valid <= eoc && act_fwd && !dma_on;
      if (eoc && act_fwd && !dma_on) fwd_data <= eoc_data;
    end
  end

  // R2
  rdy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(data_rdy) |-> $past(cpu_rd || (dma_ack && dma_req)));
  // R3
  ovr_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_flag) |-> $past(eoc && data_rdy));
  // R4
  keep_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !act_ow) |=> $stable(data_out));
  // R6
  ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovr_flag) |-> $past(ovr_clr));
  // R9
  unl_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_unl && eoc && data_rdy && !dma_ack && !cpu_rd) |=> ovr_flag);
endmodule

// File: tb/test_adc_result_port.sv
module test_adc_result_port;
  localparam int DW = 8;
  localparam int CW = 3;

  logic clk = 0, rst_n = 0, conv_busy = 0, cfg_ovr_overwrite = 0;
  logic [1:0] cfg_xfer_mode = 0;
  logic [CW-1:0] cfg_xfer_len = 0;
  logic cfg_dma_load = 0, cfg_fwd_en = 0, ovr_irq_en = 0;
  logic eoc = 0, cpu_rd = 0, dma_ack = 0, ovr_clr = 0;
  logic [DW-1:0] eoc_data = 0;
  logic [DW-1:0] data_out, fwd_data;
  logic data_rdy, dma_req, ovr_flag, ovr_irq, fwd_valid;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  adc_result_port #(.DATA_W(DW), .CNT_W(CW)) i_adc_result_port (
    .clk, .rst_n, .conv_busy, .cfg_ovr_overwrite, .cfg_xfer_mode,
    .cfg_xfer_len, .cfg_dma_load, .cfg_fwd_en, .ovr_irq_en, .eoc,
    .eoc_data, .cpu_rd, .dma_ack, .ovr_clr, .data_out, .data_rdy,
    .dma_req, .ovr_flag, .ovr_irq, .fwd_valid, .fwd_data);

  task automatic tick; @(posedge clk); #1; endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic conv(input int d);
    eoc = 1; eoc_data = DW'(d); tick; eoc = 0;
  endtask

  task automatic rd; cpu_rd = 1; tick; cpu_rd = 0; endtask
  task automatic ack; dma_ack = 1; tick; dma_ack = 0; endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    tick; tick;
    chk("R1 data_out", data_out, 0); chk("R1 data_rdy", data_rdy, 0);
    chk("R1 dma_req", dma_req, 0);   chk("R1 ovr_flag", ovr_flag, 0);
    chk("R1 ovr_irq", ovr_irq, 0);   chk("R1 fwd_valid", fwd_valid, 0);
    rst_n = 1; tick;

    // R2 basic capture and read
    conv(8'h5A);
    chk("R2 data", data_out, 8'h5A); chk("R2 rdy set", data_rdy, 1);
    chk("R7 none no req", dma_req, 0);
    rd; chk("R2 rdy clear", data_rdy, 0);

    // R3 R4 R5 R6 policy x irq sweep
    for (int ow = 0; ow < 2; ow++)
      for (int ie = 0; ie < 2; ie++) begin
        cfg_ovr_overwrite = 1'(ow); ovr_irq_en = 1'(ie); tick;
        conv(16 + ow * 4 + ie);
        conv(64 + ow * 4 + ie);
        chk(ow ? "R5 overwrite data" : "R4 keep data", data_out,
            ow ? 64 + ow * 4 + ie : 16 + ow * 4 + ie);
        chk("R3 ovr set", ovr_flag, 1);
        chk("R6 irq", ovr_irq, ie);
        tick; chk("R6 sticky", ovr_flag, 1);
        ovr_clr = 1; tick; ovr_clr = 0;
        chk("R6 cleared", ovr_flag, 0);
        rd; chk("R2 rdy after read", data_rdy, 0);
      end

    // R3 read coincident with eoc: no overrun
    conv(3);
    cpu_rd = 1; conv(4); cpu_rd = 0;
    chk("R3 no ovr on coincident read", ovr_flag, 0);
    chk("R3 new data loaded", data_out, 4);
    chk("R3 rdy stays", data_rdy, 1);

    // R13 ack without request ignored
    ack; chk("R13 ack ignored", data_rdy, 1);
    cfg_xfer_mode = 2'b11; tick;
    chk("R7 mode 11 no req", dma_req, 0);
    rd;

    // R8 limited sweep over lengths
    for (int len = 1; len <= 4; len++) begin
      cfg_xfer_mode = 2'b01; cfg_xfer_len = CW'(len); cfg_dma_load = 1;
      tick; cfg_dma_load = 0;
      for (int k = 0; k < len + 2; k++) begin
        conv(len * 16 + k);
        chk("R8 data", data_out, len * 16 + k);
        chk("R8 req", dma_req, (k < len) ? 1 : 0);
        if (k < len) begin ack; chk("R8 ack clears rdy", data_rdy, 0); end
        else rd;
      end
    end

    // R10 reload count
    conv(99); chk("R10 req before load", dma_req, 0);
    cfg_dma_load = 1; tick; cfg_dma_load = 0;
    chk("R10 req after load", dma_req, 1);
    ack;

    // R9 unlimited
    cfg_xfer_mode = 2'b10; tick;
    for (int k = 0; k < 6; k++) begin
      conv(k + 200); chk("R9 req each", dma_req, 1); ack;
    end
    conv(1); conv(2);
    chk("R9 ovr when ack stops", ovr_flag, 1);
    chk("R9 req still", dma_req, 1);
    ovr_clr = 1; cpu_rd = 1; tick; ovr_clr = 0; cpu_rd = 0;

    // R11 forwarding
    cfg_xfer_mode = 2'b00; cfg_fwd_en = 1; tick;
    conv(77);
    chk("R11 fwd valid", fwd_valid, 1); chk("R11 fwd data", fwd_data, 77);
    tick; chk("R11 one cycle", fwd_valid, 0);
    rd;
    cfg_xfer_mode = 2'b10; tick;
    conv(55); chk("R11 blocked by dma", fwd_valid, 0);
    ack;

    // R12 busy gating
    cfg_fwd_en = 0; cfg_xfer_mode = 2'b00; tick;
    conv(11);
    conv_busy = 1; cfg_xfer_mode = 2'b10; tick;
    chk("R12 mode held while busy", dma_req, 0);
    conv_busy = 0; tick;
    chk("R12 mode applied when idle", dma_req, 1);
    ack;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule